// File: doc/BRIEF.md
# Predicated Vector Loop Step Sequencer

This block walks the element loop of one vector instruction. It keeps two independent cursors, one for the source side and one for the destination side. Each cursor holds an element step and a sub-element step. A start strobe opens a new instruction. Each advance strobe moves both cursors one position forward. The block reports when the loop has reached its final position and when no enabled element is left.

Each side has its own predicate mask. Whenever a side's sub-element step returns to 0, its element step jumps forward past masked-off elements in a single cycle. A per-side zeroing flag turns that skip off, so every element is visited. A per-side hold input keeps that side's element step in place while its sub-element step still wraps around. All outputs come straight from registers, or from comparisons on registers.

Top module: `vec_step_seq`

## Requirements
- R1: While `rst` is high at a clock edge, both element steps and both sub-element steps become 0 at that edge.
- R2: A `start` pulse, which has priority over `advance`, sets both sub-element steps to 0 and sets each side's element step to the skip result (R6) taken from candidate 0.
- R3: `subvl` value s means s+1 sub-elements. On an accepted advance, a side whose sub-element step is below `subvl` increments its sub-element step and keeps its element step.
- R4: On an accepted advance, a side whose sub-element step equals `subvl` clears its sub-element step to 0. It then sets its element step to the skip result (R6) taken from the old step plus one.
- R5: With that side's hold input high, the wrap of R4 takes the skip result from the unchanged old step instead of old step plus one.
- R6: Skip result from candidate c: the lowest index k with c <= k < `vl` whose mask bit `mask[k]` is 1. Indices of 64 and above read as 0. If no such index exists the result is `vl`. If c >= `vl` the result is c.
- R7: When a side's zeroing flag is high, its skip result is the candidate itself.
- R8: The two sides use separate masks, flags, holds and sub-element steps, and never affect each other.
- R9: `loop_end` is high when `vl` is nonzero and either (source step == `vl`-1 and source sub-step == `subvl`) or (destination step == `vl`-1 and destination sub-step == `subvl`).
- R10: `no_more` is high when either element step equals `vl`.
- R11: An `advance` while `loop_end` or `no_more` is high is ignored, and all four steps keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new instruction's loop |
| advance | input | 1 | Move both cursors one position |
| vl | input | 7 | Vector length |
| subvl | input | 2 | Sub-element count minus one |
| src_mask | input | 64 | Source predicate mask |
| dst_mask | input | 64 | Destination predicate mask |
| src_zero | input | 1 | Source zeroing: no skipping |
| dst_zero | input | 1 | Destination zeroing: no skipping |
| src_hold | input | 1 | Keep source element step on wrap |
| dst_hold | input | 1 | Keep destination element step on wrap |
| src_step | output | 7 | Source element step |
| src_sub | output | 2 | Source sub-element step |
| dst_step | output | 7 | Destination element step |
| dst_sub | output | 2 | Destination sub-element step |
| loop_end | output | 1 | Final position reached on either side |
| no_more | output | 1 | A side ran out of enabled elements |

## Verification
The bench targets a sparse source mask against a full destination mask. If the design shared one sub-step or one skip between the sides, the destination cursor would be dragged along to the source's positions. Mask bits at index 63 and the absence of set bits beyond it probe the scan range. A design that wrapped the index or scanned past `vl` would land on a wrong step instead of reporting `no_more`. Further cases are hold-on-wrap, zeroing with an empty mask, `vl` of 0, and advances after loop end. A design getting these wrong would move a step forward, skip elements it must visit, or keep counting past the end.

// File: rtl/vss_pkg.sv
package vss_pkg;
  typedef enum logic [1:0] {
    UPD_KEEP = 2'd0,
    UPD_LOAD = 2'd1,
    UPD_MOVE = 2'd2
  } upd_e;
endpackage

// File: rtl/vss_next_elem.sv
module vss_next_elem #(
  parameter int STEP_W = 7,
  parameter int MASK_W = 64
) (
  input  logic [STEP_W-1:0] cand,
  input  logic [STEP_W-1:0] vl,
  input  logic [MASK_W-1:0] mask,
  input  logic              zero,
  output logic [STEP_W-1:0] res
);
  localparam int NSTEP = 1 << STEP_W;

  logic [NSTEP-1:0] mpad;

  always_comb begin
    mpad = '0;
    mpad[MASK_W-1:0] = mask;
  end

  // lowest enabled index in [cand, vl); vl when none
  always_comb begin
    res = vl;
    if (zero || cand >= vl) begin
      res = cand;
    end else begin
      for (int i = NSTEP - 1; i >= 0; i--) begin
        if (STEP_W'(i) >= cand && STEP_W'(i) < vl && mpad[i]) res = STEP_W'(i);
      end
    end
  end
endmodule

// File: rtl/vss_cursor.sv
module vss_cursor
  import vss_pkg::*;
#(
  parameter int STEP_W = 7,
  parameter int SUB_W  = 2,
  parameter int MASK_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  upd_e              upd,
  input  logic              hold,
  input  logic              zero,
  input  logic [MASK_W-1:0] mask,
  input  logic [STEP_W-1:0] vl,
  input  logic [SUB_W-1:0]  subvl,
  output logic [STEP_W-1:0] step,
  output logic [SUB_W-1:0]  sub
);
  logic              wrap;
  logic [STEP_W-1:0] cand;
  logic [SUB_W-1:0]  sub_nx;
  logic [STEP_W-1:0] skipped;
  logic [STEP_W-1:0] step_nx;

  assign wrap = (sub == subvl);

  always_comb begin
    if (upd == UPD_LOAD) begin
      cand   = '0;
      sub_nx = '0;
    end else if (wrap) begin
      cand   = hold ? step : step + STEP_W'(1);
      sub_nx = '0;
    end else begin
      cand   = step;
      sub_nx = sub + SUB_W'(1);
    end
  end

  vss_next_elem #(.STEP_W(STEP_W), .MASK_W(MASK_W)) u_skip (
    .cand (cand),
    .vl   (vl),
    .mask (mask),
    .zero (zero),
    .res  (skipped)
  );

  // skipping only takes place when the sub-step lands on 0
  assign step_nx = (sub_nx == '0) ? skipped : cand;

  always_ff @(posedge clk) begin
    if (rst) begin
      step <= '0;
      sub  <= '0;
    end else if (upd != UPD_KEEP) begin
      step <= step_nx;
      sub  <= sub_nx;
    end
  end
endmodule

// File: rtl/vec_step_seq.sv
module vec_step_seq
  import vss_pkg::*;
#(
  parameter int STEP_W = 7,
  parameter int SUB_W  = 2,
  parameter int MASK_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              advance,
  input  logic [STEP_W-1:0] vl,
  input  logic [SUB_W-1:0]  subvl,
  input  logic [MASK_W-1:0] src_mask,
  input  logic [MASK_W-1:0] dst_mask,
  input  logic              src_zero,
  input  logic              dst_zero,
  input  logic              src_hold,
  input  logic              dst_hold,
  output logic [STEP_W-1:0] src_step,
  output logic [SUB_W-1:0]  src_sub,
  output logic [STEP_W-1:0] dst_step,
  output logic [SUB_W-1:0]  dst_sub,
  output logic              loop_end,
  output logic              no_more
);
  localparam logic [STEP_W-1:0] ONE = STEP_W'(1);

  upd_e upd;
  logic src_fin, dst_fin;

  assign src_fin  = (src_step == vl - ONE) && (src_sub == subvl);
  assign dst_fin  = (dst_step == vl - ONE) && (dst_sub == subvl);
  assign loop_end = (vl != '0) && (src_fin || dst_fin);
  assign no_more  = (src_step == vl) || (dst_step == vl);

  always_comb begin
    if (start)                                   upd = UPD_LOAD;
    else if (advance && !loop_end && !no_more)   upd = UPD_MOVE;
    else                                         upd = UPD_KEEP;
  end

  vss_cursor #(.STEP_W(STEP_W), .SUB_W(SUB_W), .MASK_W(MASK_W)) u_src (
    .clk (clk), .rst (rst), .upd (upd), .hold (src_hold), .zero (src_zero),
    .mask (src_mask), .vl (vl), .subvl (subvl), .step (src_step), .sub (src_sub)
  );

  vss_cursor #(.STEP_W(STEP_W), .SUB_W(SUB_W), .MASK_W(MASK_W)) u_dst (
    .clk (clk), .rst (rst), .upd (upd), .hold (dst_hold), .zero (dst_zero),
    .mask (dst_mask), .vl (vl), .subvl (subvl), .step (dst_step), .sub (dst_sub)
  );
endmodule

// File: rtl/vec_step_seq_chk.sv
module vec_step_seq_chk #(
  parameter int STEP_W = 7,
  parameter int SUB_W  = 2,
  parameter int MASK_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              advance,
  input logic [STEP_W-1:0] vl,
  input logic [SUB_W-1:0]  subvl,
  input logic [MASK_W-1:0] src_mask,
  input logic [MASK_W-1:0] dst_mask,
  input logic              src_zero,
  input logic              dst_zero,
  input logic              src_hold,
  input logic              dst_hold,
  input logic [STEP_W-1:0] src_step,
  input logic [SUB_W-1:0]  src_sub,
  input logic [STEP_W-1:0] dst_step,
  input logic [SUB_W-1:0]  dst_sub,
  input logic              loop_end,
  input logic              no_more
);
  logic go;
  assign go = advance && !start && !loop_end && !no_more;

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (src_step == '0 && src_sub == '0 && dst_step == '0 && dst_sub == '0));

  p_start_sub_r2: assert property (@(posedge clk) disable iff (rst)
    start |=> (src_sub == '0 && dst_sub == '0));

  p_sub_inc_r3: assert property (@(posedge clk) disable iff (rst)
    (go && src_sub != subvl) |=> (src_sub == $past(src_sub) + SUB_W'(1) && src_step == $past(src_step)));

  p_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (go && dst_sub == subvl && !dst_hold) |=> (dst_sub == '0 && dst_step > $past(dst_step)));

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (go && src_sub == subvl && src_hold && src_zero) |=> (src_sub == '0 && src_step == $past(src_step)));

  p_ignore_r11: assert property (@(posedge clk) disable iff (rst)
    (advance && !start && loop_end) |=>
      ($stable(src_step) && $stable(src_sub) && $stable(dst_step) && $stable(dst_sub)));
endmodule

bind vec_step_seq vec_step_seq_chk #(.STEP_W(STEP_W), .SUB_W(SUB_W), .MASK_W(MASK_W)) u_chk (.*);

// File: tb/vec_step_seq_bench.sv
`timescale 1ns/1ps
module vec_step_seq_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0, advance = 1'b0;
  logic [6:0]  vl = '0;
  logic [1:0]  subvl = '0;
  logic [63:0] src_mask = '0, dst_mask = '0;
  logic        src_zero = 1'b0, dst_zero = 1'b0, src_hold = 1'b0, dst_hold = 1'b0;
  logic [6:0]  src_step, dst_step;
  logic [1:0]  src_sub, dst_sub;
  logic        loop_end, no_more;

  int n_chk = 0, n_fail = 0;
  int ms = 0, mss = 0, md = 0, mds = 0;

  always #2.5 clk = ~clk;

  vec_step_seq u_vec_step_seq (.*);

  function automatic int skip_to(int c, logic [63:0] m, int v, logic z);
    if (z || c >= v) return c;
    for (int k = c; k < v; k++) if (k < 64 && m[k]) return k;
    return v;
  endfunction

  function automatic bit m_end();
    int v = int'(vl);
    int s = int'(subvl);
    return v != 0 && ((ms == v - 1 && mss == s) || (md == v - 1 && mds == s));
  endfunction

  function automatic bit m_none();
    return ms == int'(vl) || md == int'(vl);
  endfunction

  task automatic model_edge();
    int v = int'(vl);
    int s = int'(subvl);
    if (rst) begin
      ms = 0; mss = 0; md = 0; mds = 0;
    end else if (start) begin
      mss = 0; mds = 0;
      ms = skip_to(0, src_mask, v, src_zero);
      md = skip_to(0, dst_mask, v, dst_zero);
    end else if (advance && !m_end() && !m_none()) begin
      if (mss == s) begin
        mss = 0;
        ms = skip_to(src_hold ? ms : ms + 1, src_mask, v, src_zero);
      end else mss++;
      if (mds == s) begin
        mds = 0;
        md = skip_to(dst_hold ? md : md + 1, dst_mask, v, dst_zero);
      end else mds++;
    end
  endtask

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic cyc(string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(tag, "src_step", int'(src_step), ms);
    chk(tag, "src_sub",  int'(src_sub),  mss);
    chk(tag, "dst_step", int'(dst_step), md);
    chk(tag, "dst_sub",  int'(dst_sub),  mds);
    chk({tag, "/R9"},  "loop_end", int'(loop_end), int'(m_end()));
    chk({tag, "/R10"}, "no_more",  int'(no_more),  int'(m_none()));
  endtask

  task automatic kick(string tag);
    start = 1'b1; cyc(tag); start = 1'b0;
  endtask

  task automatic run(string tag, int n);
    advance = 1'b1;
    for (int i = 0; i < n; i++) cyc(tag);
    advance = 1'b0;
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    @(negedge clk);
    for (int i = 0; i < 3; i++) cyc("R1");
    rst = 1'b0;
    // R2: sparse source mask (bits 5,7), full destination mask
    vl = 7'd8; subvl = 2'd1; src_mask = 64'hA0; dst_mask = '1;
    kick("R2");
    run("R3", 3);
    run("R11", 6);
    // R7: zeroing visits every element even with an empty mask
    src_zero = 1'b1; dst_zero = 1'b1; src_mask = '0; dst_mask = '0; subvl = 2'd0;
    kick("R7");
    run("R7", 10);
    // R10: empty mask without zeroing exhausts the source side at once
    src_zero = 1'b0;
    kick("R10");
    run("R10", 3);
    // R6: scan reaches bit 63, then runs off into vl
    vl = 7'd100; src_mask = (64'd1 << 63) | 64'd4; dst_mask = '1; dst_zero = 1'b0;
    kick("R6");
    run("R6", 4);
    // R5: hold on the source side while the destination moves on
    vl = 7'd6; subvl = 2'd2; src_mask = 64'h2D; dst_mask = '1; src_hold = 1'b1;
    kick("R5");
    run("R5", 8);
    src_hold = 1'b0;
    run("R4", 10);
    // R11: start wins over advance; vl of zero
    vl = 7'd0; advance = 1'b1; start = 1'b1; cyc("R11"); start = 1'b0;
    cyc("R11"); advance = 1'b0;
    // R8: random mixed traffic
    for (int i = 0; i < 3000; i++) begin
      if (($urandom % 16) == 0) begin
        start = 1'b1;
        vl = 7'($urandom % 128);
        subvl = 2'($urandom % 4);
        src_mask = {$urandom, $urandom};
        dst_mask = {$urandom, $urandom} | {$urandom, $urandom};
        src_zero = (($urandom % 5) == 0);
        dst_zero = (($urandom % 5) == 0);
      end else start = 1'b0;
      advance  = (($urandom % 4) != 0);
      src_hold = (($urandom % 8) == 0);
      dst_hold = (($urandom % 8) == 0);
      cyc("R8");
    end
    start = 1'b0; advance = 1'b0;
    rst = 1'b1; cyc("R1"); rst = 1'b0;
    finish_up();
  end
endmodule